// File: doc/BRIEF.md
# Set/Clear Mask Interrupt Controller

This block gathers a small number of level-sensitive interrupt inputs and turns them into one interrupt request for a processor, together with a vector for the source that should be served. A source counts as enabled only when every enable bit tied to it is set. Enable bits sit in several mask registers, and one source may have bits in more than one of them. A source is pending when its input is high and it is enabled.

Software reaches each mask register through two addresses on a simple register bus. A write to the first address sets the bits given in the data. A write to the second address clears them. A read of either address returns the stored value. Only the low 29 address bits are decoded, so windows that differ in the top three bits reach the same register.

The processor side supplies its current interrupt mask level. The block answers with the vector of the lowest-numbered pending source and a valid flag. Source slots marked as reserved have no vector. Their enable bits cannot be written, and they never become pending.

Top module: `sc_intc`

## Requirements
- R1: After reset every mask register reads 0, `cpu_irq` is low, `cpu_vec_valid` is low and `cpu_vec` is 0.
- R2: A write to the set address of mask register r (byte address 0x40 + 8·r) ORs `bus_wdata[7:0]` into the writable bits of that register.
- R3: A write to the clear address of mask register r (byte address 0x44 + 8·r) clears every writable bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R4: A combinational read of either the set address or the clear address returns the stored mask, zero-extended to 32 bits. Any address that decodes to no register reads 0.
- R5: Only `bus_addr[28:0]` is decoded. For example, 0xE000_0048 reaches the same register as 0x0000_0048.
- R6: Bit b of mask register r enables source (b + 3·r) mod 8. A source is pending from the clock edge after its input is high while all of its enable bits are set. If any one of its enable bits is clear, the source is not pending.
- R7: `cpu_irq` is high while at least one source is pending and low when none is.
- R8: When several sources are pending, the lowest-numbered source wins. `cpu_vec` is then 0x200 + 0x20·index.
- R9: When `cpu_imask` is 4'hF, `cpu_vec_valid` is low and `cpu_vec` is 0, while `cpu_irq` still follows the pending state. For any other mask level the winning vector is valid.
- R10: Source 7 is reserved, which means it has no vector. Its enable bits (register 0 bit 7, register 1 bit 4) ignore writes and read 0, and source 7 never becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 32 | Register bus address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; the low 8 bits are used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 8 | Level-sensitive interrupt inputs, one per source |
| cpu_imask | input | 4 | Processor interrupt mask level |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | 12 | Vector of the winning source |
| cpu_vec_valid | output | 1 | High when `cpu_vec` holds a vector to be taken |

## Verification
A corrupted mask bit shows up on `bus_rdata` as soon as the register is read back. It also shows on `cpu_irq` one clock after the affected source's input goes high: the request either appears although an enable bit is clear, or it stays low although every enable bit is set. A fault in the bit-to-source mapping or in the priority order shows as a wrong `cpu_vec` in the cycle after two sources are pending together. The directed scenarios therefore enable sources one bit at a time, so that each missing bit is seen at the ports.

// File: rtl/sc_intc_pkg.sv
`timescale 1ns/1ps
package sc_intc_pkg;
  // Source controlled by bit b of mask register r.
  function automatic int src_of(input int r, input int b, input int rot, input int nsrc);
    return (b + r * rot) % nsrc;
  endfunction
endpackage

// File: rtl/sc_intc_maskreg.sv
`timescale 1ns/1ps
module sc_intc_maskreg #(
  parameter int REG_IDX = 0,
  parameter int REG_W   = 8,
  parameter int NUM_SRC = 8,
  parameter int SRC_ROT = 3,
  parameter logic [NUM_SRC-1:0] RSV_SRC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_hit,
  input  logic             clr_hit,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  import sc_intc_pkg::*;

  function automatic logic [REG_W-1:0] calc_wmask();
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W; b++)
      m[b] = !RSV_SRC[src_of(REG_IDX, b, SRC_ROT, NUM_SRC)];
    return m;
  endfunction

  localparam logic [REG_W-1:0] WMASK = calc_wmask();

  logic [REG_W-1:0] q_d;
  logic             q_en;
  logic [REG_W-1:0] wbits;

  assign wbits = wdata & WMASK;
  assign q_en  = set_hit | clr_hit;

  always_comb begin
    q_d = q;
    if (set_hit)      q_d = q | wbits;
    else if (clr_hit) q_d = q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((q & $past(wbits)) == $past(wbits)) && ((q & ~$past(wbits)) == ($past(q) & ~$past(wbits))));

  assert_clr_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((q & $past(wbits)) == '0) && ((q & ~$past(wbits)) == ($past(q) & ~$past(wbits))));

  assert_rsv_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~WMASK) == '0);
endmodule

// File: rtl/sc_intc_pend.sv
`timescale 1ns/1ps
module sc_intc_pend #(
  parameter int NUM_SRC = 8,
  parameter int NUM_REG = 2,
  parameter int REG_W   = 8,
  parameter int SRC_ROT = 3,
  parameter logic [NUM_SRC-1:0] RSV_SRC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REG*REG_W-1:0] masks,
  input  logic [NUM_SRC-1:0]       src_in,
  output logic [NUM_SRC-1:0]       pend_q
);
  import sc_intc_pkg::*;

  logic [NUM_SRC-1:0] en_all;
  logic [NUM_SRC-1:0] pend_d;
  logic               pend_en;

  // A source is enabled when no bit tied to it is clear (set count == total count).
  always_comb begin
    en_all = '1;
    for (int s = 0; s < NUM_SRC; s++)
      for (int r = 0; r < NUM_REG; r++)
        for (int b = 0; b < REG_W; b++)
          if (src_of(r, b, SRC_ROT, NUM_SRC) == s && !masks[r*REG_W + b])
            en_all[s] = 1'b0;
  end

  assign pend_d  = src_in & en_all & ~RSV_SRC;
  assign pend_en = (pend_d != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
      assert_pend_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[s] |-> $past(src_in[s]));
      if (RSV_SRC[s]) begin : g_rsv
        assert_rsv_never_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
          !pend_q[s]);
      end
    end
  endgenerate
endmodule

// File: rtl/sc_intc_pick.sv
`timescale 1ns/1ps
module sc_intc_pick #(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 'h200,
  parameter int VEC_STEP = 'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [3:0]         imask,
  output logic               irq,
  output logic [VEC_W-1:0]   vec,
  output logic               vec_valid
);
  int   win_idx;
  logic any_pend;
  logic masked;

  always_comb begin
    win_idx = 0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend[i]) win_idx = i;
  end

  assign any_pend  = |pend;
  assign masked    = (imask == 4'hF);
  assign irq       = any_pend;
  assign vec_valid = any_pend && !masked;
  assign vec       = vec_valid ? VEC_W'(VEC_BASE + win_idx * VEC_STEP) : '0;

  assert_vec_needs_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> irq);

  assert_masked_no_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == 4'hF) |-> (!vec_valid && vec == '0));
endmodule

// File: rtl/sc_intc.sv
`timescale 1ns/1ps
module sc_intc #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int DEC_W    = 29,
  parameter int NUM_SRC  = 8,
  parameter int NUM_REG  = 2,
  parameter int REG_W    = 8,
  parameter int SRC_ROT  = 3,
  parameter logic [NUM_SRC-1:0] RSV_SRC = 8'h80,
  parameter logic [31:0] REG_BASE = 32'h0000_0040,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 'h200,
  parameter int VEC_STEP = 'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [3:0]         cpu_imask,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   cpu_vec,
  output logic               cpu_vec_valid
);
  localparam int REG_STRIDE = 8;
  localparam int CLR_OFS    = 4;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  logic [DEC_W-1:0]         dec_addr;
  logic                     unused_bus_bits;
  logic [NUM_REG-1:0]       set_match, clr_match;
  logic [NUM_REG*REG_W-1:0] masks;
  logic [NUM_SRC-1:0]       pend_q;

  assign dec_addr        = bus_addr[DEC_W-1:0];
  assign unused_bus_bits = ^{bus_addr[ADDR_W-1:DEC_W], bus_wdata[DATA_W-1:REG_W]};

  generate
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      assign set_match[r] = (dec_addr == DEC_W'(REG_BASE + 32'(r * REG_STRIDE)));
      assign clr_match[r] = (dec_addr == DEC_W'(REG_BASE + 32'(r * REG_STRIDE + CLR_OFS)));

      sc_intc_maskreg #(
        .REG_IDX(r), .REG_W(REG_W), .NUM_SRC(NUM_SRC),
        .SRC_ROT(SRC_ROT), .RSV_SRC(RSV_SRC)
      ) mreg_i (
        .clk    (clk),
        .rst_n  (rst_sn),
        .set_hit(bus_we && set_match[r]),
        .clr_hit(bus_we && clr_match[r]),
        .wdata  (bus_wdata[REG_W-1:0]),
        .q      (masks[r*REG_W +: REG_W])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REG; r++)
      if (set_match[r] || clr_match[r])
        bus_rdata[REG_W-1:0] = masks[r*REG_W +: REG_W];
  end

  sc_intc_pend #(
    .NUM_SRC(NUM_SRC), .NUM_REG(NUM_REG), .REG_W(REG_W),
    .SRC_ROT(SRC_ROT), .RSV_SRC(RSV_SRC)
  ) pend_i (
    .clk   (clk),
    .rst_n (rst_sn),
    .masks (masks),
    .src_in(src_in),
    .pend_q(pend_q)
  );

  sc_intc_pick #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) pick_i (
    .clk      (clk),
    .rst_n    (rst_sn),
    .pend     (pend_q),
    .imask    (cpu_imask),
    .irq      (cpu_irq),
    .vec      (cpu_vec),
    .vec_valid(cpu_vec_valid)
  );

  // R4: set and clear windows of one register can never both match.
  assert_one_window_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({set_match, clr_match}));
endmodule

// File: tb/sc_intc_tb.sv
`timescale 1ns/1ps
module sc_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_in = '0;
  logic [3:0]  cpu_imask = 4'h0;
  logic        cpu_irq;
  logic [11:0] cpu_vec;
  logic        cpu_vec_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sc_intc dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .cpu_imask(cpu_imask), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
    .cpu_vec_valid(cpu_vec_valid)
  );

  localparam logic [31:0] SET0 = 32'h40, CLR0 = 32'h44, SET1 = 32'h48, CLR1 = 32'h4C;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bread(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [11:0] vec_of(input int s);
    return 12'(32'h200 + s * 32'h20);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    bread(SET0, d); chk("R1 reg0 after reset", d, 0);
    bread(CLR1, d); chk("R1 reg1 after reset", d, 0);
    chk("R1 irq after reset", 32'(cpu_irq), 0);
    chk("R1 valid after reset", 32'(cpu_vec_valid), 0);
    chk("R1 vec after reset", 32'(cpu_vec), 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    bwrite(SET0, 32'h0F); bread(SET0, d); chk("R2 set 0F", d, 32'h0F);
    bwrite(SET0, 32'h30); bread(SET0, d); chk("R2 set OR 30", d, 32'h3F);
    bwrite(CLR0, 32'h05); bread(SET0, d); chk("R3 clear 05", d, 32'h3A);
    bread(CLR0, d); chk("R4 read via clear addr", d, 32'h3A);
    bwrite(CLR0, 32'hFF); bread(CLR0, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    bwrite(32'hE000_0048, 32'h21); bread(SET1, d); chk("R5 high-window write", d, 32'h21);
    bread(32'hA000_004C, d); chk("R5 high-window read", d, 32'h21);
    bread(32'h0000_0060, d); chk("R4 unmapped reads 0", d, 0);
    bwrite(CLR1, 32'hFF);
  endtask

  task automatic t_pending();
    // source 0: reg0 bit0 and reg1 bit5
    src_in = 8'h01;
    bwrite(SET0, 32'h01); settle();
    chk("R6 one of two enables not pending", 32'(cpu_irq), 0);
    bwrite(SET1, 32'h20); settle();
    chk("R6 all enables pending", 32'(cpu_irq), 1);
    chk("R8 vector source 0", 32'(cpu_vec), 32'(vec_of(0)));
    chk("R9 valid at imask 0", 32'(cpu_vec_valid), 1);
    src_in = 8'h00; settle();
    chk("R7 irq drops when input low", 32'(cpu_irq), 0);
    src_in = 8'h01;
    bwrite(CLR0, 32'h01); settle();
    chk("R6 cleared enable drops pending", 32'(cpu_irq), 0);
    src_in = 8'h00;
    bwrite(CLR1, 32'hFF);
  endtask

  task automatic t_priority();
    // sources 2 and 5: reg0 bits 2,5; reg1 bits 7,2
    bwrite(SET0, 32'h24); bwrite(SET1, 32'h84);
    src_in = 8'h24; settle();
    chk("R8 lowest index wins", 32'(cpu_vec), 32'(vec_of(2)));
    src_in = 8'h20; settle();
    chk("R8 source 5 vector", 32'(cpu_vec), 32'(vec_of(5)));
    chk("R7 irq with one pending", 32'(cpu_irq), 1);
    cpu_imask = 4'hF; #2;
    chk("R9 masked no valid", 32'(cpu_vec_valid), 0);
    chk("R9 masked vec zero", 32'(cpu_vec), 0);
    chk("R9 irq still high", 32'(cpu_irq), 1);
    cpu_imask = 4'hE; #2;
    chk("R9 imask E valid", 32'(cpu_vec_valid), 1);
    cpu_imask = 4'h0;
    src_in = 8'h00; settle();
    chk("R7 irq low when none pending", 32'(cpu_irq), 0);
    bwrite(CLR0, 32'hFF); bwrite(CLR1, 32'hFF);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    bwrite(SET0, 32'h80); bread(SET0, d); chk("R10 reg0 bit7 ignored", d, 0);
    bwrite(SET1, 32'h10); bread(SET1, d); chk("R10 reg1 bit4 ignored", d, 0);
    bwrite(SET0, 32'hFF); bwrite(SET1, 32'hFF);
    bread(SET0, d); chk("R10 reg0 reads 7F", d, 32'h7F);
    bread(SET1, d); chk("R10 reg1 reads EF", d, 32'hEF);
    src_in = 8'h80; settle();
    chk("R10 reserved never pending", 32'(cpu_irq), 0);
    src_in = 8'h00;
    bwrite(CLR0, 32'hFF); bwrite(CLR1, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_clear();
    t_alias();
    t_pending();
    t_priority();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule